// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Unit

This block moves one byte at a time over a serial link that carries a separate transfer clock. A host writes a byte on a simple write strobe; the unit shifts it out on a data output while it shifts a byte in from a data input. The byte that comes in is then presented on a parallel read port. A single empty flag tells the host when the shifter and its one-entry holding buffer have both drained.

The transfer clock has two sources. In the first, the unit generates it from the system clock through a prescaler (1, 8 or 32) followed by a reload counter, and drives it out. In the second, the unit follows a clock that arrives on an input pin. That clock passes through a two-flop synchronizer, and its edges are detected in the system clock domain.

Configuration inputs set four things: which clock edge launches data and which captures it, whether the first bit is the most or least significant, and whether the data lines are inverted. A three-bit mode input is shared with other serial modes, and this unit acts only when that input holds 001.

Top module: `csio_shift_unit`

## Requirements
- R1: After reset, tx_empty is 1, rd_data is 0, sdo is 1 (with inversion off) and sclk_o sits at its idle level.
- R2: When cfg_mode is any value other than 3'b001, host writes are ignored: tx_empty stays 1, sclk_o does not toggle and sclk_oe is 0.
- R3: In internal-clock mode (cfg_ext_clk = 0, mode 001), sclk_oe is 1. Each byte produces exactly 8 clock pulses, and between transfers sclk_o rests at the inverse of cfg_clk_pol.
- R4: In internal-clock mode, each half period of sclk_o lasts P*(cfg_brg+1) system clocks. P is 1 for cfg_div_sel = 0, 8 for 1, and 32 for 2 and for 3.
- R5: With cfg_clk_pol = 0, sdo changes on falling edges of the transfer clock and sdi is sampled on rising edges. With cfg_clk_pol = 1, the two edges are swapped.
- R6: With cfg_msb_first = 0, bit 0 of the byte goes first on both lines. With cfg_msb_first = 1, bit 7 goes first.
- R7: With cfg_invert = 1, the level driven on sdo is the complement of the data bit, and the level read on sdi is complemented before it is stored.
- R8: tx_empty falls in the cycle after an accepted write. It rises in the cycle of the eighth capture edge, unless another byte is pending.
- R9: rd_data takes the received byte in the system clock cycle of the eighth capture edge, and holds it until the next transfer completes.
- R10: A write during a transfer is held in a one-entry buffer and starts by itself as soon as the current byte completes, and tx_empty stays 0 across the boundary. A further write while a byte is pending replaces the pending byte.
- R11: With cfg_ext_clk = 1, sclk_oe is 0. Launch and capture follow the synchronized edges of sclk_i, with the same polarity, order and inversion rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Serial mode field; 001 enables this unit |
| cfg_ext_clk | input | 1 | 0: generate transfer clock, 1: follow sclk_i |
| cfg_clk_pol | input | 1 | Launch/capture edge pair select |
| cfg_msb_first | input | 1 | 0: LSB first, 1: MSB first |
| cfg_invert | input | 1 | Invert serial data levels |
| cfg_div_sel | input | 2 | Prescaler select (1, 8, 32, 32) |
| cfg_brg | input | 8 | Reload value of the half-period counter |
| wr_en | input | 1 | Host write strobe for the transmit byte |
| wr_data | input | 8 | Transmit byte |
| rd_data | output | 8 | Last received byte |
| tx_empty | output | 1 | 1 when no byte is shifting or pending |
| sclk_o | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Output enable for sclk_o |
| sclk_i | input | 1 | External transfer clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest case to reach is the hand-off at the exact cycle of a transfer's last capture edge. There the pending byte must load, the half-period counter must restart, rd_data must update, and tx_empty must not blink. To reach it, the bench writes a first byte and then runs a slave model of the link alongside more writes, so that bytes queue while the first is still shifting and a second queued byte overwrites the first one. The slave checks that the line carries the first and last bytes back to back, and that rd_data changes twice.

// File: rtl/csio_pkg.sv
// Shared constants and types for the clock-synchronous serial shift unit.
package csio_pkg;
    // Mode field value that enables clock-synchronous operation.
    localparam logic [2:0] MODE_CLKSYNC = 3'b001;

    // Prescaler choices ahead of the half-period counter.
    typedef enum logic [1:0] {
        PRE_DIV1   = 2'd0,
        PRE_DIV8   = 2'd1,
        PRE_DIV32  = 2'd2,
        PRE_DIV32B = 2'd3
    } prescale_e;
endpackage

// File: rtl/csio_clkgen.sv
// Internal transfer clock generator.
// Prescales clk by 1/8/32 and counts brg+1 prescaled ticks per half period.
// Emits a launch pulse when leaving idle phase and a capture pulse when returning.
// Assumes: run is low between transfers; restart reloads counters for a new byte.
module csio_clkgen
    import csio_pkg::*;
#(
    parameter int BRG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [1:0]       div_sel,
    input  logic [BRG_W-1:0] brg,
    output logic             launch,
    output logic             capture,
    output logic             phase
);
    localparam int PRE_W = 5;

    logic [PRE_W-1:0] pre_q;
    logic [BRG_W-1:0] bcnt_q;
    logic             phase_q;
    logic             pre_tick;
    logic             half_tick;
    prescale_e        sel;

    // Decode the prescaler terminal count.
    always_comb begin
        sel = prescale_e'(div_sel);
        unique case (sel)
            PRE_DIV1: pre_tick = 1'b1;
            PRE_DIV8: pre_tick = (pre_q[2:0] == 3'd7);
            default:  pre_tick = (pre_q == {PRE_W{1'b1}});
        endcase
    end

    assign half_tick = run & pre_tick & (bcnt_q == '0);

    // Prescaler and half-period reload counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            pre_q  <= '0;
            bcnt_q <= brg;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (pre_tick) begin
                bcnt_q <= (bcnt_q == '0) ? brg : bcnt_q - 1'b1;
            end
        end
    end

    // Clock phase: 0 is idle, toggles on each half-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= 1'b0;
        end else if (half_tick) begin
            phase_q <= ~phase_q;
        end
    end

    assign launch  = half_tick & ~phase_q;
    assign capture = half_tick & phase_q;
    assign phase   = phase_q;
endmodule

// File: rtl/csio_sync.sv
// Synchronizer and edge detector for an asynchronous clock input.
// Assumes: STAGES >= 2; input edges are at least a few system clocks apart.
module csio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the input through the synchronizer chain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~prev_q;
    assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/csio_shifter.sv
// Byte shifter with a one-entry transmit holding buffer.
// Launch pulses drive the next bit on sdo; capture pulses sample sdi and count bits.
// Assumes: launch and capture never fire in the same cycle.
module csio_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              launch,
    input  logic              capture,
    input  logic              msb_first,
    input  logic              invert,
    input  logic              sdi,
    output logic              sdo,
    output logic              busy,
    output logic              restart,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rd_data
);
    localparam int          CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_q, rx_q, rd_q, buf_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q, buf_full_q, sdo_q;
    logic              wr_acc, done, rx_bit;
    logic [DATA_W-1:0] rx_next;

    assign wr_acc  = wr_en & accept_en;
    assign done    = busy_q & capture & (cnt_q == LAST);
    assign rx_bit  = sdi ^ invert;
    assign rx_next = msb_first ? {rx_q[DATA_W-2:0], rx_bit} : {rx_bit, rx_q[DATA_W-1:1]};
    assign restart = (wr_acc & ~busy_q) | (done & (buf_full_q | wr_acc));

    // Shift register, bit counter and completion handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            sdo_q  <= 1'b1;
        end else if (!busy_q) begin
            if (wr_acc) begin
                tx_q   <= wr_data;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end
        end else begin
            if (launch) begin
                sdo_q <= msb_first ? tx_q[DATA_W-1] : tx_q[0];
                tx_q  <= msb_first ? (tx_q << 1) : (tx_q >> 1);
            end
            if (capture) begin
                rx_q  <= rx_next;
                cnt_q <= cnt_q + 1'b1;
                if (done) begin
                    cnt_q <= '0;
                    rd_q  <= rx_next;
                    if (buf_full_q) begin
                        tx_q <= buf_q;
                    end else if (wr_acc) begin
                        tx_q <= wr_data;
                    end else begin
                        busy_q <= 1'b0;
                    end
                end
            end
        end
    end

    // One-entry holding buffer; a newer write replaces a pending byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q      <= '0;
            buf_full_q <= 1'b0;
        end else if (wr_acc && busy_q && !(done && !buf_full_q)) begin
            buf_q      <= wr_data;
            buf_full_q <= 1'b1;
        end else if (done && buf_full_q) begin
            buf_full_q <= 1'b0;
        end
    end

    assign sdo      = sdo_q ^ invert;
    assign busy     = busy_q;
    assign tx_empty = ~busy_q & ~buf_full_q;
    assign rd_data  = rd_q;
endmodule

// File: rtl/csio_shift_unit.sv
// Top of the clock-synchronous serial shift unit.
// Selects internal (generated) or external (synchronized) transfer clock edges,
// maps the clock polarity onto launch/capture, and drives the clock output.
// Assumes: configuration inputs are held steady while a byte is shifting.
module csio_shift_unit
    import csio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BRG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_ext_clk,
    input  logic              cfg_clk_pol,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic [1:0]        cfg_div_sel,
    input  logic [BRG_W-1:0]  cfg_brg,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sclk_i,
    output logic              sdo,
    input  logic              sdi
);
    logic mode_ok, busy, restart;
    logic int_launch, int_capture, int_phase;
    logic ext_rise, ext_fall, ext_launch, ext_capture;
    logic launch, capture;

    assign mode_ok = (cfg_mode == MODE_CLKSYNC);

    csio_clkgen #(.BRG_W(BRG_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy & ~cfg_ext_clk),
        .restart (restart),
        .div_sel (cfg_div_sel),
        .brg     (cfg_brg),
        .launch  (int_launch),
        .capture (int_capture),
        .phase   (int_phase)
    );

    csio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sclk_i),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    // Polarity 0: launch on falling, capture on rising; polarity 1 swaps them.
    assign ext_launch  = cfg_clk_pol ? ext_rise : ext_fall;
    assign ext_capture = cfg_clk_pol ? ext_fall : ext_rise;
    assign launch      = cfg_ext_clk ? ext_launch  : int_launch;
    assign capture     = cfg_ext_clk ? ext_capture : int_capture;

    csio_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_en (mode_ok),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .launch    (launch),
        .capture   (capture),
        .msb_first (cfg_msb_first),
        .invert    (cfg_invert),
        .sdi       (sdi),
        .sdo       (sdo),
        .busy      (busy),
        .restart   (restart),
        .tx_empty  (tx_empty),
        .rd_data   (rd_data)
    );

    // Idle level is the inverse of the polarity bit; phase 1 is the active half.
    assign sclk_o  = int_phase ^ ~cfg_clk_pol;
    assign sclk_oe = mode_ok & ~cfg_ext_clk;
endmodule

// File: rtl/csio_shift_unit_chk.sv
// Assertion checker for csio_shift_unit, attached by bind.
module csio_shift_unit_chk
    import csio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cfg_mode,
    input logic              cfg_ext_clk,
    input logic              cfg_clk_pol,
    input logic              cfg_invert,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              tx_empty,
    input logic              sclk_o,
    input logic              sdo
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (sclk_o == ~cfg_clk_pol)); // R3

    AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != MODE_CLKSYNC) && tx_empty |=> tx_empty); // R2

    AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (cfg_mode == MODE_CLKSYNC) |=> !tx_empty); // R8

    AST_SDO_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ext_clk && !$past(cfg_ext_clk) && $stable(cfg_invert) && $stable(cfg_clk_pol)
        && (sdo != $past(sdo))
        |-> (sclk_o == cfg_clk_pol) && ($past(sclk_o) != cfg_clk_pol)); // R5

    AST_RD_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ext_clk && $stable(cfg_clk_pol) && (rd_data != $past(rd_data))
        |-> (sclk_o == ~cfg_clk_pol) && ($past(sclk_o) == cfg_clk_pol)); // R9
endmodule

bind csio_shift_unit csio_shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cfg_ext_clk (cfg_ext_clk),
    .cfg_clk_pol (cfg_clk_pol),
    .cfg_invert  (cfg_invert),
    .wr_en       (wr_en),
    .rd_data     (rd_data),
    .tx_empty    (tx_empty),
    .sclk_o      (sclk_o),
    .sdo         (sdo)
);

// File: tb/csio_shift_unit_tb_top.sv
// Directed bench for csio_shift_unit; each task drives one scenario and checks it.
module csio_shift_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'b001;
    logic       cfg_ext_clk = 1'b0;
    logic       cfg_clk_pol = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [1:0] cfg_div_sel = 2'd0;
    logic [7:0] cfg_brg = 8'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       tx_empty, sclk_o, sclk_oe, sdo;
    logic       sclk_i = 1'b1;
    logic       sdi = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int edges = 0;

    csio_shift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_ext_clk(cfg_ext_clk),
        .cfg_clk_pol(cfg_clk_pol), .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .cfg_div_sel(cfg_div_sel), .cfg_brg(cfg_brg), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tx_empty(tx_empty), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .sclk_i(sclk_i), .sdo(sdo), .sdi(sdi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(sclk_o) edges = edges + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input bit ext, input bit pol, input bit msb, input bit inv,
                           input logic [1:0] dsel, input logic [7:0] brg);
        @(negedge clk);
        cfg_ext_clk = ext;
        cfg_clk_pol = pol;
        cfg_msb_first = msb;
        cfg_invert = inv;
        cfg_div_sel = dsel;
        cfg_brg = brg;
        sclk_i = ~pol;
        repeat (6) @(negedge clk);
    endtask

    // Slave model for one byte over the generated clock.
    task automatic xfer_int(input logic [7:0] tx, input logic [7:0] rx, input int exp_half,
                            input bit more, input string tag);
        logic [7:0] got;
        int t_l, t_c;
        got = '0; t_l = 0; t_c = 0;
        for (int k = 0; k < 8; k++) begin
            int pos;
            pos = cfg_msb_first ? 7 - k : k;
            wait (sclk_o == cfg_clk_pol);
            #1;
            if (k == 0) t_l = cyc;
            sdi = rx[pos] ^ cfg_invert;
            wait (sclk_o == ~cfg_clk_pol);
            #1;
            if (k == 0) t_c = cyc;
            got[pos] = sdo ^ cfg_invert;
        end
        check(got == tx, tag, "byte seen on sdo", got, tx);
        check(rd_data == rx, "R9", "rd_data at last capture", rd_data, rx);
        check(tx_empty == !more, more ? "R10" : "R8", "tx_empty after byte", tx_empty, !more);
        if (exp_half > 0)
            check((t_c - t_l) == exp_half, "R4", "half period cycles", t_c - t_l, exp_half);
    endtask

    // Bench acts as clock master over sclk_i for one byte.
    task automatic xfer_ext(input logic [7:0] tx, input logic [7:0] rx, input string tag);
        logic [7:0] got;
        got = '0;
        do_write(tx);
        for (int k = 0; k < 8; k++) begin
            int pos;
            pos = cfg_msb_first ? 7 - k : k;
            sclk_i = cfg_clk_pol;
            sdi = rx[pos] ^ cfg_invert;
            repeat (6) @(negedge clk);
            got[pos] = sdo ^ cfg_invert;
            sclk_i = ~cfg_clk_pol;
            repeat (6) @(negedge clk);
        end
        check(got == tx, tag, "ext byte on sdo", got, tx);
        check(rd_data == rx, "R11", "ext rd_data", rd_data, rx);
        check(tx_empty == 1'b1, "R11", "ext tx_empty", tx_empty, 1);
        check(sclk_oe == 1'b0, "R11", "sclk_oe in ext mode", sclk_oe, 0);
    endtask

    task automatic t_reset;
        check(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);
        check(rd_data == 8'h00, "R1", "rd_data after reset", rd_data, 0);
        check(sclk_o == 1'b1, "R1", "sclk_o idle after reset", sclk_o, 1);
        check(sdo == 1'b1, "R1", "sdo after reset", sdo, 1);
        check(sclk_oe == 1'b1, "R3", "sclk_oe internal", sclk_oe, 1);
    endtask

    task automatic t_gate;
        @(negedge clk);
        cfg_mode = 3'b101;
        edges = 0;
        do_write(8'h5A);
        repeat (40) @(negedge clk);
        check(tx_empty == 1'b1, "R2", "tx_empty in other mode", tx_empty, 1);
        check(edges == 0, "R2", "sclk edges in other mode", edges, 0);
        check(sclk_oe == 1'b0, "R2", "sclk_oe in other mode", sclk_oe, 0);
        check(sdo == 1'b1, "R2", "sdo untouched", sdo, 1);
        cfg_mode = 3'b001;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_basic;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd1);
        edges = 0;
        do_write(8'hA5);
        xfer_int(8'hA5, 8'h3C, 2, 1'b0, "R5");
        repeat (20) @(negedge clk);
        check(edges == 16, "R3", "eight pulses then idle", edges, 16);
        check(sclk_o == 1'b1, "R3", "idle level pol0", sclk_o, 1);
    endtask

    task automatic t_pol_msb;
        set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 8'd0);
        check(sclk_o == 1'b0, "R3", "idle level pol1", sclk_o, 0);
        do_write(8'h96);
        xfer_int(8'h96, 8'h0F, 8, 1'b0, "R6");
    endtask

    task automatic t_invert;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'd0);
        do_write(8'h3E);
        xfer_int(8'h3E, 8'hC1, 32, 1'b0, "R7");
        set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 8'd0);
        do_write(8'h81);
        xfer_int(8'h81, 8'h7E, 32, 1'b0, "R7");
    endtask

    task automatic t_buffer;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd2);
        do_write(8'h11);
        fork
            begin
                xfer_int(8'h11, 8'h44, 3, 1'b1, "R10");
                xfer_int(8'h33, 8'h55, 3, 1'b0, "R10");
            end
            begin
                do_write(8'h22);
                do_write(8'h33);
                check(tx_empty == 1'b0, "R10", "tx_empty with byte queued", tx_empty, 0);
            end
        join
    endtask

    task automatic t_external;
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
        check(sclk_oe == 1'b0, "R11", "sclk_oe ext", sclk_oe, 0);
        xfer_ext(8'hC3, 8'h5B, "R11");
        set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'd0);
        xfer_ext(8'h1D, 8'hE2, "R11");
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_basic();
        t_pol_msb();
        t_invert();
        t_buffer();
        t_external();
        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end
endmodule